// File: doc/BRIEF.md
# Dual-Lane Operand Forwarding Selector

This block resolves the source operands of up to two instructions leaving the read stage in the same cycle. Each instruction carries up to two sources, so there are four operand slots. For every slot the block compares the source register number against the destination tags of the producers still in flight. Four producers can hand a value back: the integer execute stage, the final floating-point execute stage, and the write-back stages of both pipelines. For each slot it picks the youngest matching value. When nothing matches, it passes the register-file read value through.

The three earlier floating-point stages compute values that cannot be forwarded yet. A source that depends on one of them is reported as not ready, so that the dispatch logic can hold the instruction. The result of each cycle is captured in output registers that feed the execution units. A slot's data, select code and ready bit therefore describe the inputs presented at the previous rising edge.

Top module: `opnd_fwd_sel`

## Requirements
- R1: While reset is low, every slot reports ready 0, select code 0 and data 0.
- R2: A slot whose source matches no valid producer shows, one clock edge after the inputs, its register-file value, select code 0 and ready 1.
- R3: A slot whose source matches the integer execute destination forwards that data with select code 1. A dependent instruction issued in the very next cycle therefore needs no gap.
- R4: A slot matching the final floating-point execute stage forwards that data with select code 2.
- R5: A slot matching the integer write-back stage forwards that data with select code 3.
- R6: A slot matching the floating-point write-back stage forwards that data with select code 4.
- R7: When an execute-stage producer and a write-back producer both match, the execute-stage value wins. Integer execute is preferred over floating-point final execute, and integer write-back over floating-point write-back.
- R8: A slot whose source matches any valid entry of the three non-forwarding floating-point stages reports ready 0, whatever else matches.
- R9: A slot whose source valid bit is low, or whose register number is 0, reports ready 1 with select code 0 and its register-file value, even if producers target that register.
- R10: A producer whose valid bit is low is never matched.
- R11: The four slots resolve independently in the same cycle, each against the same producer set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcVld | input | 4 | Per-slot source present |
| srcReg | input | 20 | Per-slot source register, slot s at bits [5s+4:5s] |
| rfData | input | 128 | Per-slot register-file read value, slot s at [32s+31:32s] |
| intEVld | input | 1 | Integer execute stage holds a result-producing instruction |
| intEDst | input | 5 | Integer execute destination register |
| intEData | input | 32 | Integer execute result |
| fpPendVld | input | 3 | Valid bits of the three non-forwarding floating-point stages |
| fpPendDst | input | 15 | Destinations of those stages, stage p at [5p+4:5p] |
| fpE4Vld | input | 1 | Final floating-point execute stage valid |
| fpE4Dst | input | 5 | Final floating-point execute destination |
| fpE4Data | input | 32 | Final floating-point execute result |
| intWVld | input | 1 | Integer write-back valid |
| intWDst | input | 5 | Integer write-back destination |
| intWData | input | 32 | Integer write-back value |
| fpWVld | input | 1 | Floating-point write-back valid |
| fpWDst | input | 5 | Floating-point write-back destination |
| fpWData | input | 32 | Floating-point write-back value |
| opData | output | 128 | Registered resolved operand per slot |
| opSel | output | 12 | Registered select code per slot, slot s at [3s+2:3s] |
| opReady | output | 4 | Registered per-slot operand-available flag |

## Verification
Each producer is matched alone on a chosen slot, so that a wrong select code or data path shows up as a mismatch in both code and value. Overlapping matches pair an execute stage with a write-back stage on the same register, which separates correct age priority from a reversed one. Every pending floating-point stage is then made to collide with a write-back match, which separates a stall from an accidental forward. Register 0, absent sources and producers with their valid bit low target live registers, which shows whether the tag compare is correctly gated. A final pattern loads all four slots with different producers at once.

// File: rtl/fwdsel_pkg.sv
package fwdsel_pkg;
  localparam int NUM_PATHS = 5;
  localparam int SEL_W = $clog2(NUM_PATHS);

  // one-hot pick index doubles as the select code
  typedef enum logic [SEL_W-1:0] {
    SEL_RF    = 3'd0,
    SEL_INT_E = 3'd1,
    SEL_FP_E4 = 3'd2,
    SEL_INT_W = 3'd3,
    SEL_FP_W  = 3'd4
  } fwdSel_e;

  typedef struct packed {
    logic [NUM_PATHS-1:0] pick;
    logic                 ready;
  } slotStrobe_t;
endpackage

// File: rtl/fwdsel_ctrl.sv
module fwdsel_ctrl
  import fwdsel_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int REG_W       = 5,
  parameter int PEND_STAGES = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SRC-1:0]           srcVld,
  input  logic [NUM_SRC*REG_W-1:0]     srcReg,
  input  logic                         intEVld,
  input  logic [REG_W-1:0]             intEDst,
  input  logic [PEND_STAGES-1:0]       fpPendVld,
  input  logic [PEND_STAGES*REG_W-1:0] fpPendDst,
  input  logic                         fpE4Vld,
  input  logic [REG_W-1:0]             fpE4Dst,
  input  logic                         intWVld,
  input  logic [REG_W-1:0]             intWDst,
  input  logic                         fpWVld,
  input  logic [REG_W-1:0]             fpWDst,
  output slotStrobe_t                  strobe [NUM_SRC]
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    logic [REG_W-1:0]       regNum;
    logic                   active;
    logic [PEND_STAGES-1:0] pendHit;
    logic                   hitE, hitE4, hitIW, hitFW;
    slotStrobe_t            stb;

    assign regNum = srcReg[s*REG_W +: REG_W];
    assign active = srcVld[s] && (regNum != '0);

    for (genvar p = 0; p < PEND_STAGES; p++) begin : g_pend
      assign pendHit[p] = fpPendVld[p] && (fpPendDst[p*REG_W +: REG_W] == regNum);
    end

    assign hitE  = intEVld && (intEDst == regNum);
    assign hitE4 = fpE4Vld && (fpE4Dst == regNum);
    assign hitIW = intWVld && (intWDst == regNum);
    assign hitFW = fpWVld  && (fpWDst  == regNum);

    always_comb begin
      stb.pick  = '0;
      stb.ready = 1'b1;
      if (!active) begin
        stb.pick[SEL_RF] = 1'b1;
      end else if (|pendHit) begin
        stb.pick[SEL_RF] = 1'b1;
        stb.ready        = 1'b0;
      end else if (hitE) begin
        stb.pick[SEL_INT_E] = 1'b1;
      end else if (hitE4) begin
        stb.pick[SEL_FP_E4] = 1'b1;
      end else if (hitIW) begin
        stb.pick[SEL_INT_W] = 1'b1;
      end else if (hitFW) begin
        stb.pick[SEL_FP_W] = 1'b1;
      end else begin
        stb.pick[SEL_RF] = 1'b1;
      end
    end

    assign strobe[s] = stb;
  end

  // two execute-stage producers writing one register means the hazard unit let a WAW through
  AST_NO_DUAL_EXEC_DST: assert property (@(posedge clk) disable iff (!rstN)
    !(intEVld && fpE4Vld && (intEDst == fpE4Dst) && (intEDst != '0))); // R7

endmodule

// File: rtl/fwdsel_dpath.sv
module fwdsel_dpath
  import fwdsel_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  slotStrobe_t               strobe [NUM_SRC],
  input  logic [NUM_SRC*DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]         intEData,
  input  logic [DATA_W-1:0]         fpE4Data,
  input  logic [DATA_W-1:0]         intWData,
  input  logic [DATA_W-1:0]         fpWData,
  output logic [NUM_SRC*DATA_W-1:0] opData,
  output logic [NUM_SRC*SEL_W-1:0]  opSel,
  output logic [NUM_SRC-1:0]        opReady
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    logic [DATA_W-1:0] paths [NUM_PATHS];
    logic [DATA_W-1:0] muxed;
    logic [SEL_W-1:0]  code;

    assign paths[SEL_RF]    = rfData[s*DATA_W +: DATA_W];
    assign paths[SEL_INT_E] = intEData;
    assign paths[SEL_FP_E4] = fpE4Data;
    assign paths[SEL_INT_W] = intWData;
    assign paths[SEL_FP_W]  = fpWData;

    always_comb begin
      muxed = '0;
      code  = '0;
      for (int k = 0; k < NUM_PATHS; k++) begin
        muxed = muxed | (paths[k] & {DATA_W{strobe[s].pick[k]}});
        code  = code  | (strobe[s].pick[k] ? SEL_W'(k) : '0);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opData[s*DATA_W +: DATA_W] <= '0;
        opSel[s*SEL_W +: SEL_W]    <= '0;
        opReady[s]                 <= 1'b0;
      end else begin
        opData[s*DATA_W +: DATA_W] <= muxed;
        opSel[s*SEL_W +: SEL_W]    <= code;
        opReady[s]                 <= strobe[s].ready;
      end
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(strobe[s].pick)); // R2
  end

endmodule

// File: rtl/opnd_fwd_sel.sv
module opnd_fwd_sel
  import fwdsel_pkg::*;
#(
  parameter int LANES        = 2,
  parameter int SRC_PER_LANE = 2,
  parameter int REG_W        = 5,
  parameter int DATA_W       = 32,
  parameter int PEND_STAGES  = 3,
  localparam int NUM_SRC     = LANES * SRC_PER_LANE
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SRC-1:0]           srcVld,
  input  logic [NUM_SRC*REG_W-1:0]     srcReg,
  input  logic [NUM_SRC*DATA_W-1:0]    rfData,
  input  logic                         intEVld,
  input  logic [REG_W-1:0]             intEDst,
  input  logic [DATA_W-1:0]            intEData,
  input  logic [PEND_STAGES-1:0]       fpPendVld,
  input  logic [PEND_STAGES*REG_W-1:0] fpPendDst,
  input  logic                         fpE4Vld,
  input  logic [REG_W-1:0]             fpE4Dst,
  input  logic [DATA_W-1:0]            fpE4Data,
  input  logic                         intWVld,
  input  logic [REG_W-1:0]             intWDst,
  input  logic [DATA_W-1:0]            intWData,
  input  logic                         fpWVld,
  input  logic [REG_W-1:0]             fpWDst,
  input  logic [DATA_W-1:0]            fpWData,
  output logic [NUM_SRC*DATA_W-1:0]    opData,
  output logic [NUM_SRC*SEL_W-1:0]     opSel,
  output logic [NUM_SRC-1:0]           opReady
);

  slotStrobe_t strobe [NUM_SRC];

  fwdsel_ctrl #(
    .NUM_SRC(NUM_SRC), .REG_W(REG_W), .PEND_STAGES(PEND_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcVld(srcVld), .srcReg(srcReg),
    .intEVld(intEVld), .intEDst(intEDst),
    .fpPendVld(fpPendVld), .fpPendDst(fpPendDst),
    .fpE4Vld(fpE4Vld), .fpE4Dst(fpE4Dst),
    .intWVld(intWVld), .intWDst(intWDst),
    .fpWVld(fpWVld), .fpWDst(fpWDst),
    .strobe(strobe)
  );

  fwdsel_dpath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rfData(rfData),
    .intEData(intEData), .fpE4Data(fpE4Data),
    .intWData(intWData), .fpWData(fpWData),
    .opData(opData), .opSel(opSel), .opReady(opReady)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    AST_IDLE_SRC_READY: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(!srcVld[s] || (srcReg[s*REG_W +: REG_W] == '0)))
      |-> (opReady[s] && (opSel[s*SEL_W +: SEL_W] == '0))); // R9

    AST_EXEC_FWD_DATA: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && (opSel[s*SEL_W +: SEL_W] == SEL_INT_E))
      |-> (opData[s*DATA_W +: DATA_W] == $past(intEData))); // R3

    for (genvar p = 0; p < PEND_STAGES; p++) begin : g_pend
      AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(srcVld[s] && (srcReg[s*REG_W +: REG_W] != '0)
           && fpPendVld[p] && (fpPendDst[p*REG_W +: REG_W] == srcReg[s*REG_W +: REG_W])))
        |-> !opReady[s]); // R8
    end
  end

endmodule

// File: tb/tb_opnd_fwd_sel.sv
module tb_opnd_fwd_sel;
  localparam int NS = 4, RW = 5, DW = 32, NP = 3, SW = 3;

  logic clk = 1'b0;
  logic rstN;
  logic [NS-1:0] srcVld;
  logic [NS*RW-1:0] srcReg;
  logic [NS*DW-1:0] rfData;
  logic intEVld, fpE4Vld, intWVld, fpWVld;
  logic [RW-1:0] intEDst, fpE4Dst, intWDst, fpWDst;
  logic [DW-1:0] intEData, fpE4Data, intWData, fpWData;
  logic [NP-1:0] fpPendVld;
  logic [NP*RW-1:0] fpPendDst;
  logic [NS*DW-1:0] opData;
  logic [NS*SW-1:0] opSel;
  logic [NS-1:0] opReady;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opnd_fwd_sel dut (
    .clk(clk), .rstN(rstN), .srcVld(srcVld), .srcReg(srcReg), .rfData(rfData),
    .intEVld(intEVld), .intEDst(intEDst), .intEData(intEData),
    .fpPendVld(fpPendVld), .fpPendDst(fpPendDst),
    .fpE4Vld(fpE4Vld), .fpE4Dst(fpE4Dst), .fpE4Data(fpE4Data),
    .intWVld(intWVld), .intWDst(intWDst), .intWData(intWData),
    .fpWVld(fpWVld), .fpWDst(fpWDst), .fpWData(fpWData),
    .opData(opData), .opSel(opSel), .opReady(opReady)
  );

  task automatic clearAll();
    srcVld = '0; srcReg = '0; rfData = '0;
    intEVld = 0; fpE4Vld = 0; intWVld = 0; fpWVld = 0;
    intEDst = '0; fpE4Dst = '0; intWDst = '0; fpWDst = '0;
    intEData = 32'hE000_0001; fpE4Data = 32'hF400_0002;
    intWData = 32'hA000_0003; fpWData = 32'hFA00_0004;
    fpPendVld = '0; fpPendDst = '0;
  endtask

  task automatic setSrc(input int s, input bit v, input int r, input logic [DW-1:0] d);
    srcVld[s] = v;
    srcReg[s*RW +: RW] = RW'(r);
    rfData[s*DW +: DW] = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int s, input int expSel, input bit expRdy,
                     input logic [DW-1:0] expD, input bit cmpData, input string req);
    logic [SW-1:0] aSel;
    logic [DW-1:0] aD;
    aSel = opSel[s*SW +: SW];
    aD = opData[s*DW +: DW];
    nChecks++;
    if (aSel !== SW'(expSel) || opReady[s] !== expRdy || (cmpData && aD !== expD)) begin
      nFails++;
      $display("FAIL %s slot%0d: sel=%0d rdy=%0b data=%h, expected sel=%0d rdy=%0b data=%h",
               req, s, aSel, opReady[s], aD, expSel, expRdy, expD);
    end
  endtask

  task automatic tReset();
    for (int s = 0; s < NS; s++) chk(s, 0, 0, '0, 1, "R1");
  endtask

  task automatic tNoMatch();
    clearAll();
    for (int s = 0; s < NS; s++) setSrc(s, 1, s + 1, 32'h1000 + s);
    intEVld = 1; intEDst = 9; intWVld = 1; intWDst = 10;
    step();
    for (int s = 0; s < NS; s++) chk(s, 0, 1, 32'h1000 + s, 1, "R2");
  endtask

  task automatic tBackToBack();
    clearAll();
    // cycle 1: ADD writing r3 enters execute; next cycle's reader of r3 forwards
    setSrc(0, 1, 3, 32'h33); intEVld = 1; intEDst = 3; intEData = 32'h0000_0ABC;
    step();
    chk(0, 1, 1, 32'h0000_0ABC, 1, "R3");
    intEData = 32'h0000_0DEF;
    step();
    chk(0, 1, 1, 32'h0000_0DEF, 1, "R3");
  endtask

  task automatic tSingles();
    clearAll();
    setSrc(1, 1, 6, 32'h66); fpE4Vld = 1; fpE4Dst = 6;
    step();
    chk(1, 2, 1, 32'hF400_0002, 1, "R4");
    clearAll();
    setSrc(2, 1, 11, 32'hBB); intWVld = 1; intWDst = 11;
    setSrc(3, 1, 12, 32'hCC); fpWVld = 1; fpWDst = 12;
    step();
    chk(2, 3, 1, 32'hA000_0003, 1, "R5");
    chk(3, 4, 1, 32'hFA00_0004, 1, "R6");
  endtask

  task automatic tPriority();
    clearAll();
    setSrc(0, 1, 8, 32'h88); intEVld = 1; intEDst = 8; intWVld = 1; intWDst = 8;
    setSrc(1, 1, 9, 32'h99); fpE4Vld = 1; fpE4Dst = 9; fpWVld = 1; fpWDst = 9;
    step();
    chk(0, 1, 1, 32'hE000_0001, 1, "R7");
    chk(1, 2, 1, 32'hF400_0002, 1, "R7");
    clearAll();
    setSrc(2, 1, 14, 32'hEE); intWVld = 1; intWDst = 14; fpWVld = 1; fpWDst = 14;
    step();
    chk(2, 3, 1, 32'hA000_0003, 1, "R7");
  endtask

  task automatic tPending();
    for (int p = 0; p < NP; p++) begin
      clearAll();
      setSrc(p, 1, 7, 32'h77);
      fpPendVld[p] = 1; fpPendDst[p*RW +: RW] = 7;
      intWVld = 1; intWDst = 7;
      setSrc(3, 1, 20, 32'h2020);
      step();
      chk(p, 0, 0, '0, 0, "R8");
      chk(3, 0, 1, 32'h2020, 1, "R8");
    end
  endtask

  task automatic tZeroAbsent();
    clearAll();
    setSrc(0, 1, 0, 32'h0);
    intEVld = 1; intEDst = 0; fpWVld = 1; fpWDst = 0;
    setSrc(1, 0, 5, 32'h55);
    fpPendVld[1] = 1; fpPendDst[1*RW +: RW] = 5; intWVld = 1; intWDst = 5;
    step();
    chk(0, 0, 1, 32'h0, 1, "R9");
    chk(1, 0, 1, 32'h55, 1, "R9");
  endtask

  task automatic tInvalidProducers();
    clearAll();
    setSrc(0, 1, 4, 32'h44); intEDst = 4;
    setSrc(1, 1, 4, 32'h45); fpE4Dst = 4; intWDst = 4; fpWDst = 4;
    fpPendDst = {3{5'd4}};
    step();
    chk(0, 0, 1, 32'h44, 1, "R10");
    chk(1, 0, 1, 32'h45, 1, "R10");
  endtask

  task automatic tFourLanes();
    clearAll();
    intEVld = 1; intEDst = 1; fpE4Vld = 1; fpE4Dst = 2;
    intWVld = 1; intWDst = 3; fpWVld = 1; fpWDst = 4;
    setSrc(0, 1, 4, 32'h4); setSrc(1, 1, 3, 32'h3);
    setSrc(2, 1, 2, 32'h2); setSrc(3, 1, 1, 32'h1);
    step();
    chk(0, 4, 1, 32'hFA00_0004, 1, "R11");
    chk(1, 3, 1, 32'hA000_0003, 1, "R11");
    chk(2, 2, 1, 32'hF400_0002, 1, "R11");
    chk(3, 1, 1, 32'hE000_0001, 1, "R11");
  endtask

  initial begin
    rstN = 0;
    clearAll();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    tNoMatch();
    tBackToBack();
    tSingles();
    tPriority();
    tPending();
    tZeroAbsent();
    tInvalidProducers();
    tFourLanes();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule